// File: doc/BRIEF.md
# Accelerometer Configuration Register Bank

This block is the byte-wide register file of a three-axis accelerometer. A generic register port presents an address, a write byte, a write strobe, a read strobe and the index of the current byte within a burst. Behind that port the bank holds the sensor's control state: power enable, full-scale range, output data rate, three per-axis offset trims, a four-bit non-volatile configuration field, the interrupt latch mode and two free-form interrupt routing bytes. Every stored field is also driven straight out as a configuration output, so the sensing logic uses it without a register read. The bank also decodes the data-rate code into a rate in millihertz and the range code into a full-scale value in g.

Each write is checked against the rules of its target register. A write that sets a reserved bit, targets a read-only or unmapped address, or arrives as the second or a later byte of a burst is discarded, and the error output pulses. Reads return the chip identity byte, the stored configuration, or the live 12-bit axis samples. The samples come in on parallel inputs and are split into a left-justified low byte and a high byte. A read burst walks the address space by adding the byte index to the base address. A read of an address with nothing mapped returns zero and raises the same error pulse.

Access sequencing is a small outcome state machine. The states are ST_IDLE (no access last cycle), ST_WR_OK (a write was accepted), ST_WR_REJ (a write was rejected), ST_RD_OK (a read hit a mapped byte) and ST_RD_MISS (a read hit an unmapped address). On every clock the next state follows from the strobes sampled in that cycle:
- a write strobe goes to ST_WR_OK or ST_WR_REJ, depending on validation;
- otherwise a read strobe goes to ST_RD_OK or ST_RD_MISS, depending on address decode;
- otherwise the machine returns to ST_IDLE.

The error output is high in ST_WR_REJ and ST_RD_MISS.

Top module: `acr_top`

## Requirements
- R1: After reset: acc_rdata is 0x00 and acc_err is 0. The configuration outputs are: cfg_accel_en 0, cfg_range_code 0 (cfg_range_g 2), cfg_rate_code 8 (cfg_rate_mhz 100000), all offsets 0x00, cfg_nv 0, cfg_int_latched 0, cfg_int1_io 0x00 and cfg_int_map 0x00.
- R2: Write timing and read timing:
  - An accepted write changes the configuration outputs on the clock edge that samples acc_wr, so the new value is visible one cycle after the strobe.
  - A read loads acc_rdata on the edge that samples acc_rd, and acc_rdata holds that value until the next read.
  - A write strobe leaves acc_rdata unchanged.
  - When acc_wr and acc_rd are both high, only the write is performed.
- R3: Range register at 0x11. A write of 0..3 sets cfg_range_code to that value, and cfg_range_g becomes 2 shifted left by the code (2, 4, 8 or 16). Readback is the code in bits 1:0 with the upper bits zero. A write value above 3 is rejected and the register is unchanged.
- R4: Acceleration config register at 0x10. It reads back as 0xA0 OR the rate code. A write is accepted only when bits 7:4 equal 0xA, and then the rate code becomes bits 3:0. Any other write is rejected and leaves the rate unchanged.
- R5: Rate decode. For a rate code n in 1..12, cfg_rate_mhz is 1600000 shifted right by 12-n, truncated. This gives 781 for code 1, 1562 for code 2, doubling up to 1600000 for code 12. Codes 0, 13, 14 and 15 give 0.
- R6: Sample bytes:
  - The X, Y and Z samples read at 0x02/0x03, 0x04/0x05 and 0x06/0x07, low byte first.
  - The low byte is {sample[3:0], 4'b0000}.
  - The high byte is sample[11:4].
- R7: A read accesses address (acc_addr + acc_bidx) modulo 256.
- R8: Address 0x00 reads 0x12. A write to it is rejected.
- R9: A write with acc_bidx not zero is rejected, whatever its address and data.
- R10: Non-volatile config register at 0x13. A write with any of bits 7:4 set is rejected. Otherwise cfg_nv becomes bits 3:0. Readback is {4'b0000, cfg_nv}.
- R11: Latch register at 0x14 and power register at 0x12:
  - The latch register accepts only 0x00 and 0x01. Its bit 0 drives cfg_int_latched (1 = latched).
  - The power register accepts only 0x00 and 0x04. Its bit 2 drives cfg_accel_en.
  - Any other value written to either register is rejected. Readback is the stored bit in its position with the other bits zero.
- R12: These registers accept any byte and read it back: interrupt pin control at 0x15 (cfg_int1_io), interrupt map at 0x16 (cfg_int_map), and X/Y/Z offsets at 0x18/0x19/0x1A.
- R13: Error reporting:
  - A read of any address not listed in R3, R4, R6, R8 and R10..R12 returns 0x00 and raises acc_err.
  - A write to such an address, or to a sample byte, is rejected.
  - Every rejected write raises acc_err.
  - acc_err is high for exactly the one cycle after the failing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 8 | Register address (burst base) |
| acc_wdata | input | 8 | Write byte |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_bidx | input | 4 | Byte index within the current burst |
| acc_rdata | output | 8 | Registered read byte |
| acc_err | output | 1 | One-cycle pulse for a rejected write or unmapped read |
| smp_x | input | 12 | X-axis sample |
| smp_y | input | 12 | Y-axis sample |
| smp_z | input | 12 | Z-axis sample |
| cfg_accel_en | output | 1 | Accelerometer enabled |
| cfg_range_code | output | 2 | Range code |
| cfg_range_g | output | 5 | Full-scale range in g |
| cfg_rate_code | output | 4 | Output data rate code |
| cfg_rate_mhz | output | 21 | Decoded rate in millihertz, 0 for reserved codes |
| cfg_off_x | output | 8 | X offset trim |
| cfg_off_y | output | 8 | Y offset trim |
| cfg_off_z | output | 8 | Z offset trim |
| cfg_nv | output | 4 | Non-volatile configuration field |
| cfg_int_latched | output | 1 | Interrupt latch mode |
| cfg_int1_io | output | 8 | Interrupt pin control byte |
| cfg_int_map | output | 8 | Interrupt map byte |

## Verification
The assertions check on every cycle that:
- an error pulse always follows a strobe;
- a rejected write leaves every configuration field untouched;
- a burst-continuation write always raises the error;
- a write strobe never disturbs the read byte;
- a chip-identity read always returns 0x12.

Only the bench's scenarios can show the rest:
- the per-register legality rules (the exact values accepted by range, acceleration config, power, latch and non-volatile config);
- the left-justified packing of the samples and burst auto-increment across all six sample bytes;
- the rate-code decode at its end points and reserved codes;
- the readback of every stored field.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int DW = 8;
    localparam int AW = 8;

    // Register addresses
    localparam logic [AW-1:0] A_CHIP_ID  = 8'h00;
    localparam logic [AW-1:0] A_SMP_BASE = 8'h02;
    localparam logic [AW-1:0] A_ACC_CFG  = 8'h10;
    localparam logic [AW-1:0] A_RANGE    = 8'h11;
    localparam logic [AW-1:0] A_POWER    = 8'h12;
    localparam logic [AW-1:0] A_NVCFG    = 8'h13;
    localparam logic [AW-1:0] A_LATCH    = 8'h14;
    localparam logic [AW-1:0] A_INT1IO   = 8'h15;
    localparam logic [AW-1:0] A_INTMAP   = 8'h16;
    localparam logic [AW-1:0] A_OFF_BASE = 8'h18;

    localparam int NAXIS       = 3;
    localparam int RATE_CW     = 4;
    localparam int RANGE_CW    = 2;
    localparam int NV_W        = 4;
    localparam int PWR_EN_BIT  = 2;
    localparam logic [3:0] ACC_CFG_TAG = 4'hA;
    localparam logic [RATE_CW-1:0] RATE_RESET = 4'd8;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_ACC,
        TGT_RANGE,
        TGT_POWER,
        TGT_NV,
        TGT_LATCH,
        TGT_INT1,
        TGT_MAP,
        TGT_OFFX,
        TGT_OFFY,
        TGT_OFFZ
    } acr_tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_OK,
        ST_WR_REJ,
        ST_RD_OK,
        ST_RD_MISS
    } acr_state_e;

    typedef struct packed {
        logic                       accel_en;
        logic [RANGE_CW-1:0]        range_code;
        logic [RATE_CW-1:0]         rate_code;
        logic [NAXIS-1:0][DW-1:0]   offset;
        logic [NV_W-1:0]            nv;
        logic                       latched;
        logic [DW-1:0]              int1_io;
        logic [DW-1:0]              int_map;
    } acr_cfg_t;

endpackage

// File: rtl/acr_validate.sv
module acr_validate
    import acr_pkg::*;
#(
    parameter int BIDX_W = 4
) (
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [BIDX_W-1:0] bidx,
    output logic              wr_ok,
    output acr_tgt_e          tgt
);

    acr_tgt_e decoded;
    logic     value_ok;

    always_comb begin
        decoded  = TGT_NONE;
        value_ok = 1'b0;
        unique case (addr)
            A_ACC_CFG: begin
                decoded  = TGT_ACC;
                value_ok = (wdata[7:4] == ACC_CFG_TAG);
            end
            A_RANGE: begin
                decoded  = TGT_RANGE;
                value_ok = (wdata[DW-1:RANGE_CW] == '0);
            end
            A_POWER: begin
                decoded  = TGT_POWER;
                value_ok = ((wdata & ~(DW'(1) << PWR_EN_BIT)) == '0);
            end
            A_NVCFG: begin
                decoded  = TGT_NV;
                value_ok = (wdata[DW-1:NV_W] == '0);
            end
            A_LATCH: begin
                decoded  = TGT_LATCH;
                value_ok = (wdata[DW-1:1] == '0);
            end
            A_INT1IO: begin
                decoded  = TGT_INT1;
                value_ok = 1'b1;
            end
            A_INTMAP: begin
                decoded  = TGT_MAP;
                value_ok = 1'b1;
            end
            A_OFF_BASE: begin
                decoded  = TGT_OFFX;
                value_ok = 1'b1;
            end
            A_OFF_BASE + 8'd1: begin
                decoded  = TGT_OFFY;
                value_ok = 1'b1;
            end
            A_OFF_BASE + 8'd2: begin
                decoded  = TGT_OFFZ;
                value_ok = 1'b1;
            end
            default: begin
                decoded  = TGT_NONE;
                value_ok = 1'b0;
            end
        endcase
    end

    // Multi-byte writes are never accepted
    assign wr_ok = value_ok && (bidx == '0);
    assign tgt   = wr_ok ? decoded : TGT_NONE;

endmodule

// File: rtl/acr_store.sv
module acr_store
    import acr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit,
    input  acr_tgt_e tgt,
    input  logic [DW-1:0] wdata,
    output acr_cfg_t cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.accel_en   <= 1'b0;
            cfg_q.range_code <= '0;
            cfg_q.rate_code  <= RATE_RESET;
            cfg_q.offset     <= '0;
            cfg_q.nv         <= '0;
            cfg_q.latched    <= 1'b0;
            cfg_q.int1_io    <= '0;
            cfg_q.int_map    <= '0;
        end else if (commit) begin
            unique case (tgt)
                TGT_ACC:   cfg_q.rate_code  <= wdata[RATE_CW-1:0];
                TGT_RANGE: cfg_q.range_code <= wdata[RANGE_CW-1:0];
                TGT_POWER: cfg_q.accel_en   <= wdata[PWR_EN_BIT];
                TGT_NV:    cfg_q.nv         <= wdata[NV_W-1:0];
                TGT_LATCH: cfg_q.latched    <= wdata[0];
                TGT_INT1:  cfg_q.int1_io    <= wdata;
                TGT_MAP:   cfg_q.int_map    <= wdata;
                TGT_OFFX:  cfg_q.offset[0]  <= wdata;
                TGT_OFFY:  cfg_q.offset[1]  <= wdata;
                TGT_OFFZ:  cfg_q.offset[2]  <= wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/acr_rate.sv
module acr_rate
    import acr_pkg::*;
#(
    parameter int RATE_W        = 21,
    parameter int RATE_TOP_MHZ  = 1600000,
    parameter int RATE_CODE_MAX = 12
) (
    input  logic [RATE_CW-1:0] code,
    output logic [RATE_W-1:0]  mhz
);

    // Each code below the top halves the rate; reserved codes decode to 0
    always_comb begin
        mhz = '0;
        for (int i = 1; i <= RATE_CODE_MAX; i++) begin
            if (code == RATE_CW'(i))
                mhz = RATE_W'(RATE_TOP_MHZ >> (RATE_CODE_MAX - i));
        end
    end

endmodule

// File: rtl/acr_readmux.sv
module acr_readmux
    import acr_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter logic [DW-1:0] CHIP_ID = 8'h12
) (
    input  logic [AW-1:0]               eff_addr,
    input  acr_cfg_t                    cfg_q,
    input  logic [NAXIS-1:0][SMP_W-1:0] smp,
    output logic [DW-1:0]               rbyte,
    output logic                        hit
);

    localparam int LO_BITS = SMP_W - DW;

    logic [NAXIS-1:0][DW-1:0] smp_lo;
    logic [NAXIS-1:0][DW-1:0] smp_hi;

    for (genvar a = 0; a < NAXIS; a++) begin : g_pack
        assign smp_lo[a] = {smp[a][LO_BITS-1:0], {(DW-LO_BITS){1'b0}}};
        assign smp_hi[a] = smp[a][SMP_W-1:LO_BITS];
    end

    always_comb begin
        rbyte = '0;
        hit   = 1'b1;
        unique case (eff_addr)
            A_CHIP_ID:  rbyte = CHIP_ID;
            A_ACC_CFG:  rbyte = {ACC_CFG_TAG, cfg_q.rate_code};
            A_RANGE:    rbyte = DW'(cfg_q.range_code);
            A_POWER:    rbyte = DW'(cfg_q.accel_en) << PWR_EN_BIT;
            A_NVCFG:    rbyte = DW'(cfg_q.nv);
            A_LATCH:    rbyte = DW'(cfg_q.latched);
            A_INT1IO:   rbyte = cfg_q.int1_io;
            A_INTMAP:   rbyte = cfg_q.int_map;
            default: begin
                hit = 1'b0;
                for (int a = 0; a < NAXIS; a++) begin
                    if (eff_addr == A_SMP_BASE + AW'(2 * a)) begin
                        rbyte = smp_lo[a];
                        hit   = 1'b1;
                    end
                    if (eff_addr == A_SMP_BASE + AW'(2 * a + 1)) begin
                        rbyte = smp_hi[a];
                        hit   = 1'b1;
                    end
                    if (eff_addr == A_OFF_BASE + AW'(a)) begin
                        rbyte = cfg_q.offset[a];
                        hit   = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/acr_top.sv
module acr_top
    import acr_pkg::*;
#(
    parameter int BIDX_W        = 4,
    parameter int SMP_W         = 12,
    parameter int RANGE_G_W     = 5,
    parameter int RATE_W        = 21,
    parameter int RATE_TOP_MHZ  = 1600000,
    parameter int RATE_CODE_MAX = 12,
    parameter logic [7:0] CHIP_ID = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        acc_addr,
    input  logic [7:0]        acc_wdata,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [BIDX_W-1:0] acc_bidx,
    output logic [7:0]        acc_rdata,
    output logic              acc_err,
    input  logic [SMP_W-1:0]  smp_x,
    input  logic [SMP_W-1:0]  smp_y,
    input  logic [SMP_W-1:0]  smp_z,
    output logic              cfg_accel_en,
    output logic [1:0]        cfg_range_code,
    output logic [RANGE_G_W-1:0] cfg_range_g,
    output logic [3:0]        cfg_rate_code,
    output logic [RATE_W-1:0] cfg_rate_mhz,
    output logic [7:0]        cfg_off_x,
    output logic [7:0]        cfg_off_y,
    output logic [7:0]        cfg_off_z,
    output logic [3:0]        cfg_nv,
    output logic              cfg_int_latched,
    output logic [7:0]        cfg_int1_io,
    output logic [7:0]        cfg_int_map
);

    acr_state_e state_q, state_d;
    acr_cfg_t   cfg_q;
    acr_tgt_e   tgt;
    logic       wr_ok;
    logic       commit;
    logic       rd_hit;
    logic [DW-1:0] rbyte;
    logic [AW-1:0] eff_addr;
    logic [NAXIS-1:0][SMP_W-1:0] smp;

    assign smp      = {smp_z, smp_y, smp_x};
    assign eff_addr = acc_addr + AW'(acc_bidx);
    assign commit   = acc_wr && wr_ok;

    acr_validate #(.BIDX_W(BIDX_W)) u_validate (
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .bidx  (acc_bidx),
        .wr_ok (wr_ok),
        .tgt   (tgt)
    );

    acr_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .tgt    (tgt),
        .wdata  (acc_wdata),
        .cfg_q  (cfg_q)
    );

    acr_readmux #(.SMP_W(SMP_W), .CHIP_ID(CHIP_ID)) u_readmux (
        .eff_addr (eff_addr),
        .cfg_q    (cfg_q),
        .smp      (smp),
        .rbyte    (rbyte),
        .hit      (rd_hit)
    );

    acr_rate #(
        .RATE_W        (RATE_W),
        .RATE_TOP_MHZ  (RATE_TOP_MHZ),
        .RATE_CODE_MAX (RATE_CODE_MAX)
    ) u_rate (
        .code (cfg_q.rate_code),
        .mhz  (cfg_rate_mhz)
    );

    // Outcome state machine: next state
    always_comb begin
        state_d = ST_IDLE;
        if (acc_wr)
            state_d = wr_ok ? ST_WR_OK : ST_WR_REJ;
        else if (acc_rd)
            state_d = rd_hit ? ST_RD_OK : ST_RD_MISS;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Read data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_rdata <= '0;
        else if (acc_rd && !acc_wr)
            acc_rdata <= rd_hit ? rbyte : '0;
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_WR_REJ, ST_RD_MISS: acc_err = 1'b1;
            ST_IDLE, ST_WR_OK, ST_RD_OK: acc_err = 1'b0;
            default: acc_err = 1'b0;
        endcase
    end

    assign cfg_accel_en    = cfg_q.accel_en;
    assign cfg_range_code  = cfg_q.range_code;
    assign cfg_range_g     = RANGE_G_W'(2) << cfg_q.range_code;
    assign cfg_rate_code   = cfg_q.rate_code;
    assign cfg_off_x       = cfg_q.offset[0];
    assign cfg_off_y       = cfg_q.offset[1];
    assign cfg_off_z       = cfg_q.offset[2];
    assign cfg_nv          = cfg_q.nv;
    assign cfg_int_latched = cfg_q.latched;
    assign cfg_int1_io     = cfg_q.int1_io;
    assign cfg_int_map     = cfg_q.int_map;

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_wr || acc_rd)); // R13

    AST_REJECT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_REJ) |-> $stable(cfg_q)); // R3

    AST_BURST_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_bidx != '0) |=> acc_err); // R9

    AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> $stable(acc_rdata)); // R2

    AST_CHIP_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && (acc_addr + AW'(acc_bidx)) == A_CHIP_ID)
        |=> (acc_rdata == CHIP_ID)); // R8

endmodule

// File: tb/tb_acr_top.sv
module tb_acr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [3:0]  acc_bidx = '0;
    logic [7:0]  acc_rdata;
    logic        acc_err;
    logic [11:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        cfg_accel_en;
    logic [1:0]  cfg_range_code;
    logic [4:0]  cfg_range_g;
    logic [3:0]  cfg_rate_code;
    logic [20:0] cfg_rate_mhz;
    logic [7:0]  cfg_off_x, cfg_off_y, cfg_off_z;
    logic [3:0]  cfg_nv;
    logic        cfg_int_latched;
    logic [7:0]  cfg_int1_io, cfg_int_map;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of stored state
    logic       m_en;
    logic [1:0] m_range;
    logic [3:0] m_rate;
    logic [7:0] m_off [3];
    logic [3:0] m_nv;
    logic       m_lat;
    logic [7:0] m_int1, m_map;

    always #2 clk = ~clk;

    acr_top dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_bidx(acc_bidx),
        .acc_rdata(acc_rdata), .acc_err(acc_err),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .cfg_accel_en(cfg_accel_en), .cfg_range_code(cfg_range_code),
        .cfg_range_g(cfg_range_g), .cfg_rate_code(cfg_rate_code),
        .cfg_rate_mhz(cfg_rate_mhz), .cfg_off_x(cfg_off_x),
        .cfg_off_y(cfg_off_y), .cfg_off_z(cfg_off_z), .cfg_nv(cfg_nv),
        .cfg_int_latched(cfg_int_latched), .cfg_int1_io(cfg_int1_io),
        .cfg_int_map(cfg_int_map)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [20:0] exp_rate(input logic [3:0] c);
        case (c)
            4'd1:  return 21'd781;
            4'd2:  return 21'd1562;
            4'd3:  return 21'd3125;
            4'd4:  return 21'd6250;
            4'd5:  return 21'd12500;
            4'd6:  return 21'd25000;
            4'd7:  return 21'd50000;
            4'd8:  return 21'd100000;
            4'd9:  return 21'd200000;
            4'd10: return 21'd400000;
            4'd11: return 21'd800000;
            4'd12: return 21'd1600000;
            default: return 21'd0;
        endcase
    endfunction

    function automatic logic legal_write(input logic [7:0] a, input logic [7:0] d,
                                         input logic [3:0] b);
        if (b != 0) return 1'b0;
        case (a)
            8'h10: return d[7:4] == 4'hA;
            8'h11: return d <= 8'd3;
            8'h12: return (d & 8'hFB) == 0;
            8'h13: return d[7:4] == 0;
            8'h14: return d <= 8'd1;
            8'h15, 8'h16, 8'h18, 8'h19, 8'h1A: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [8:0] exp_read(input logic [7:0] a); // {hit, byte}
        case (a)
            8'h00: return {1'b1, 8'h12};
            8'h02: return {1'b1, smp_x[3:0], 4'h0};
            8'h03: return {1'b1, smp_x[11:4]};
            8'h04: return {1'b1, smp_y[3:0], 4'h0};
            8'h05: return {1'b1, smp_y[11:4]};
            8'h06: return {1'b1, smp_z[3:0], 4'h0};
            8'h07: return {1'b1, smp_z[11:4]};
            8'h10: return {1'b1, 4'hA, m_rate};
            8'h11: return {1'b1, 6'h0, m_range};
            8'h12: return {1'b1, 5'h0, m_en, 2'b00};
            8'h13: return {1'b1, 4'h0, m_nv};
            8'h14: return {1'b1, 7'h0, m_lat};
            8'h15: return {1'b1, m_int1};
            8'h16: return {1'b1, m_map};
            8'h18: return {1'b1, m_off[0]};
            8'h19: return {1'b1, m_off[1]};
            8'h1A: return {1'b1, m_off[2]};
            default: return 9'h000;
        endcase
    endfunction

    task automatic model_reset();
        m_en = 0; m_range = 0; m_rate = 4'd8; m_nv = 0; m_lat = 0;
        m_int1 = 0; m_map = 0;
        for (int i = 0; i < 3; i++) m_off[i] = 0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h10: m_rate = d[3:0];
            8'h11: m_range = d[1:0];
            8'h12: m_en = d[2];
            8'h13: m_nv = d[3:0];
            8'h14: m_lat = d[0];
            8'h15: m_int1 = d;
            8'h16: m_map = d;
            8'h18: m_off[0] = d;
            8'h19: m_off[1] = d;
            8'h1A: m_off[2] = d;
            default: ;
        endcase
    endtask

    task automatic check_cfg(input string tag);
        check({tag, " en"},      32'(cfg_accel_en),    32'(m_en));
        check({tag, " range"},   32'(cfg_range_code),  32'(m_range));
        check({tag, " range_g"}, 32'(cfg_range_g),     32'(2) << m_range);
        check({tag, " rate"},    32'(cfg_rate_code),   32'(m_rate));
        check({tag, " rate_mhz"},32'(cfg_rate_mhz),    32'(exp_rate(m_rate)));
        check({tag, " offx"},    32'(cfg_off_x),       32'(m_off[0]));
        check({tag, " offy"},    32'(cfg_off_y),       32'(m_off[1]));
        check({tag, " offz"},    32'(cfg_off_z),       32'(m_off[2]));
        check({tag, " nv"},      32'(cfg_nv),          32'(m_nv));
        check({tag, " latch"},   32'(cfg_int_latched), 32'(m_lat));
        check({tag, " int1"},    32'(cfg_int1_io),     32'(m_int1));
        check({tag, " map"},     32'(cfg_int_map),     32'(m_map));
    endtask

    // Drive a write, sample the outcome one cycle later at a falling edge
    task automatic do_write(input string tag, input logic [7:0] a, input logic [7:0] d,
                            input logic [3:0] b);
        logic ok;
        logic [7:0] old_rd;
        ok = legal_write(a, d, b);
        old_rd = acc_rdata;
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_bidx = b; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_bidx = 0;
        if (ok) model_write(a, d);
        check({tag, " err"}, 32'(acc_err), 32'(!ok));
        check({tag, " rdata kept (R2)"}, 32'(acc_rdata), 32'(old_rd));
        check_cfg(tag);
    endtask

    task automatic do_read(input string tag, input logic [7:0] a, input logic [3:0] b);
        logic [8:0] e;
        @(negedge clk);
        acc_addr = a; acc_bidx = b; acc_rd = 1'b1;
        e = exp_read(a + 8'(b));
        @(negedge clk);
        acc_rd = 1'b0; acc_bidx = 0;
        check({tag, " rdata"}, 32'(acc_rdata), 32'(e[7:0]));
        check({tag, " err"},   32'(acc_err),   32'(!e[8]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4417));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", 32'(acc_rdata), 32'h0);
        check("R1 err", 32'(acc_err), 32'h0);
        check_cfg("R1");

        // R8 chip id
        do_read("R8 chip id", 8'h00, 4'd0);
        do_write("R8 write id", 8'h00, 8'h55, 4'd0);

        // R6/R7 sample packing and burst
        smp_x = 12'hABC; smp_y = 12'h123; smp_z = 12'hF0E;
        for (int i = 0; i < 6; i++) do_read("R6 R7 sample burst", 8'h02, 4'(i));
        do_read("R7 wrap", 8'hFF, 4'd1);
        do_write("R13 write sample", 8'h03, 8'h11, 4'd0);

        // R3 range
        for (int i = 0; i < 4; i++) begin
            do_write("R3 range", 8'h11, 8'(i), 4'd0);
            do_read("R3 readback", 8'h11, 4'd0);
        end
        do_write("R3 range reject", 8'h11, 8'h04, 4'd0);
        do_write("R3 range reject hi", 8'h11, 8'h81, 4'd0);

        // R4 / R5 acc config and rate decode
        do_write("R4 acc cfg", 8'h10, 8'hA5, 4'd0);
        do_read("R4 readback", 8'h10, 4'd0);
        do_write("R4 reject", 8'h10, 8'h53, 4'd0);
        do_write("R5 code1", 8'h10, 8'hA1, 4'd0);
        do_write("R5 code12", 8'h10, 8'hAC, 4'd0);
        do_write("R5 code0", 8'h10, 8'hA0, 4'd0);
        do_write("R5 code13", 8'h10, 8'hAD, 4'd0);
        do_write("R5 code15", 8'h10, 8'hAF, 4'd0);

        // R9 burst write
        do_write("R9 burst write", 8'h15, 8'h3C, 4'd1);

        // R10 nv
        do_write("R10 nv", 8'h13, 8'h0F, 4'd0);
        do_write("R10 nv reject", 8'h13, 8'h10, 4'd0);
        do_read("R10 readback", 8'h13, 4'd0);

        // R11 latch and power
        do_write("R11 power on", 8'h12, 8'h04, 4'd0);
        do_write("R11 power reject", 8'h12, 8'h05, 4'd0);
        do_read("R11 power readback", 8'h12, 4'd0);
        do_write("R11 latch", 8'h14, 8'h01, 4'd0);
        do_write("R11 latch reject", 8'h14, 8'h02, 4'd0);
        do_read("R11 latch readback", 8'h14, 4'd0);

        // R12 free registers
        do_write("R12 int1", 8'h15, 8'hC3, 4'd0);
        do_write("R12 map", 8'h16, 8'h7E, 4'd0);
        do_write("R12 offz", 8'h1A, 8'hFF, 4'd0);
        do_read("R12 offz readback", 8'h18, 4'd2);

        // R13 unmapped
        do_read("R13 unmapped", 8'h30, 4'd0);
        do_write("R13 unmapped write", 8'h01, 8'h00, 4'd0);
        @(negedge clk);
        check("R13 err single pulse", 32'(acc_err), 32'h0);

        // R2 simultaneous strobes: write wins, rdata unchanged
        begin
            logic [7:0] old_rd;
            old_rd = acc_rdata;
            @(negedge clk);
            acc_addr = 8'h16; acc_wdata = 8'h99; acc_bidx = 0;
            acc_wr = 1'b1; acc_rd = 1'b1;
            @(negedge clk);
            acc_wr = 1'b0; acc_rd = 1'b0;
            model_write(8'h16, 8'h99);
            check("R2 both strobes rdata", 32'(acc_rdata), 32'(old_rd));
            check("R2 both strobes err", 32'(acc_err), 32'h0);
            check_cfg("R2 both strobes");
        end

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [7:0] a, d;
            logic [3:0] b;
            op = $urandom_range(0, 9);
            a  = 8'($urandom_range(0, 31));
            d  = 8'($urandom);
            if (op < 2) begin
                smp_x = 12'($urandom); smp_y = 12'($urandom); smp_z = 12'($urandom);
            end else if (op < 6) begin
                b = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
                if ($urandom_range(0, 1) == 1) begin
                    case (a)
                        8'h10: d = {4'hA, d[3:0]};
                        8'h11: d = {6'h0, d[1:0]};
                        8'h12: d = {5'h0, d[2], 2'b00};
                        8'h13: d = {4'h0, d[3:0]};
                        8'h14: d = {7'h0, d[0]};
                        default: ;
                    endcase
                end
                do_write("R13 random write", a, d, b);
            end else begin
                b = 4'($urandom_range(0, 7));
                do_read("R7 random read", a, b);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule